// File: doc/BRIEF.md
# Toggle-Based Event Pulse Synchronizer

This block carries single-cycle event strobes, such as a periodic clock-enable tick, from one clock domain into a second domain whose clock is unrelated to the first. Each strobe in the source domain inverts a held level. That level is the only signal that crosses the boundary. In the destination domain a chain of flip-flops resynchronizes it, and a change detector turns every inversion, whether upward or downward, back into a strobe exactly one destination cycle wide.

The block carries events one way only. Events going the other way need a second instance. Each domain has its own active-low asynchronous reset. The crossing is the single path from the source toggle flop (`xing_lvl`) to the first destination flop (`meta_q` inside the level synchronizer). Only this path may be exempted from timing analysis, so the naming keeps it easy to find. Strobes must be spaced at least three destination periods apart so that two inversions never merge.

Top module: `evt_pulse_sync`

## Requirements
- R1: After both resets are released, and while `src_pulse_i` stays 0, `dst_pulse_o` stays 0.
- R2: When strobes are spaced at least four destination periods apart, each one-cycle strobe on `src_pulse_i` produces exactly one strobe on `dst_pulse_o`. None is lost and none is doubled.
- R3: `dst_pulse_o` is never high on two consecutive destination clock cycles.
- R4: For odd-numbered events after reset, the crossing level goes from 0 to 1. The output strobe appears after the 2nd or 3rd rising `dst_clk_i` edge that follows the `src_clk_i` edge capturing the event.
- R5: For even-numbered events after reset, the crossing level goes from 1 to 0. These events are delivered with the same 2-to-3 edge latency as in R4.
- R6: If both domains are reset while the crossing level is 1, no strobe appears after release, and the next event is delivered normally.
- R7: When strobes are spaced by the minimum of three destination periods, the output strobe count still equals the input count.
- R8: R2 through R5 hold whether the destination clock is faster, slower, or within 0.4 % of the source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Source domain clock |
| src_rst_ni | input | 1 | Source domain asynchronous reset, active low |
| src_pulse_i | input | 1 | One-cycle event strobe, source domain |
| dst_clk_i | input | 1 | Destination domain clock |
| dst_rst_ni | input | 1 | Destination domain asynchronous reset, active low |
| dst_pulse_o | output | 1 | One-cycle event strobe, destination domain |

## Verification
Isolated strobes are sent with the destination clock set to a faster rate, a slower rate, a nearly equal rate and a slightly slower near rate. For each strobe the bench counts destination edges from launch to output. Odd and even events are scored apart, so a detector that reacts to only one direction of level change fails on every second event. A dense burst at the minimum spacing separates a correct design from one whose detector or chain merges neighbouring inversions. A mid-run reset of both domains with the level held at 1 exposes a spurious strobe on release.

// File: rtl/evt_sync_pkg.sv
package evt_sync_pkg;

  localparam int unsigned MinSyncStages = 2;

  function automatic int unsigned clamp_stages(input int unsigned req);
    return (req < MinSyncStages) ? MinSyncStages : req;
  endfunction

endpackage

// File: rtl/evt_src_toggle.sv
module evt_src_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic lvl_o
);

  logic tgl_q;

  // flop output drives the crossing directly, no logic after it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tgl_q <= 1'b0;
    else if (pulse_i) tgl_q <= ~tgl_q;
  end

  assign lvl_o = tgl_q;

  a_r2_flip_on_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> (lvl_o != $past(lvl_o)));

  a_r1_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_i |=> $stable(lvl_o));

endmodule

// File: rtl/evt_level_sync.sv
module evt_level_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic lvl_o
);

  logic [STAGES-1:0] stage_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_meta
      // meta_q: sole receiver of the asynchronous crossing
      logic meta_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) meta_q <= 1'b0;
        else         meta_q <= lvl_i;
      end
      assign stage_q[g] = meta_q;
    end else begin : g_hold
      logic hold_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hold_q <= 1'b0;
        else         hold_q <= stage_q[g-1];
      end
      assign stage_q[g] = hold_q;
    end
  end

  assign lvl_o = stage_q[STAGES-1];

endmodule

// File: rtl/evt_change_det.sv
module evt_change_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic pulse_o
);

  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  // either direction of change yields one strobe
  assign pulse_o = lvl_i ^ prev_q;

  a_r3_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  a_r5_any_edge_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i != $past(lvl_i)) |-> pulse_o);

endmodule

// File: rtl/evt_pulse_sync.sv
module evt_pulse_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic src_clk_i,
  input  logic src_rst_ni,
  input  logic src_pulse_i,
  input  logic dst_clk_i,
  input  logic dst_rst_ni,
  output logic dst_pulse_o
);

  import evt_sync_pkg::*;

  localparam int unsigned NStages = clamp_stages(SYNC_STAGES);

  logic xing_lvl;
  logic dst_lvl;

  evt_src_toggle u_src (
    .clk_i   (src_clk_i),
    .rst_ni  (src_rst_ni),
    .pulse_i (src_pulse_i),
    .lvl_o   (xing_lvl)
  );

  evt_level_sync #(.STAGES(NStages)) u_sync (
    .clk_i  (dst_clk_i),
    .rst_ni (dst_rst_ni),
    .lvl_i  (xing_lvl),
    .lvl_o  (dst_lvl)
  );

  evt_change_det u_det (
    .clk_i   (dst_clk_i),
    .rst_ni  (dst_rst_ni),
    .lvl_i   (dst_lvl),
    .pulse_o (dst_pulse_o)
  );

  a_r6_quiet_on_release: assert property (@(posedge dst_clk_i) disable iff (!dst_rst_ni)
    $rose(dst_rst_ni) |-> !dst_pulse_o);

endmodule

// File: tb/evt_pulse_sync_test.sv
module evt_pulse_sync_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic src_clk = 1'b0;
  logic dst_clk = 1'b0;
  logic src_rst_n = 1'b0;
  logic dst_rst_n = 1'b0;
  logic src_pulse = 1'b0;
  logic dst_pulse;

  real dst_half = 4.9815;

  int checks = 0;
  int failures = 0;
  int pulse_cnt = 0;
  int wide_cnt = 0;
  int dst_edges = 0;
  int launch_edges = 0;
  int last_lat = 0;
  int events_sent = 0;
  bit prev_hi = 1'b0;
  bit done = 1'b0;

  evt_pulse_sync uut (
    .src_clk_i   (src_clk),
    .src_rst_ni  (src_rst_n),
    .src_pulse_i (src_pulse),
    .dst_clk_i   (dst_clk),
    .dst_rst_ni  (dst_rst_n),
    .dst_pulse_o (dst_pulse)
  );

  always #5 src_clk = ~src_clk;

  initial begin
    #1.7;
    forever #(dst_half) dst_clk = ~dst_clk;
  end

  always @(posedge dst_clk) dst_edges++;

  always @(negedge dst_clk) begin
    if (dst_rst_n) begin
      if (dst_pulse) begin
        pulse_cnt++;
        last_lat = dst_edges - launch_edges;
        if (prev_hi) wide_cnt++;
      end
      prev_hi = dst_pulse;
    end else begin
      prev_hi = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic launch();
    @(negedge src_clk) src_pulse = 1'b1;
    @(posedge src_clk) launch_edges = dst_edges;
    @(negedge src_clk) src_pulse = 1'b0;
    events_sent++;
  endtask

  task automatic idle_src(input int n);
    for (int i = 0; i < n; i++) @(negedge src_clk);
  endtask

  task automatic sweep_isolated(input real half, input int n);
    int gap;
    int base;
    dst_half = half;
    idle_src(4);
    gap = int'($ceil(12.0 * half / 5.0)) + 3;
    for (int i = 0; i < n; i++) begin
      base = pulse_cnt;
      launch();
      idle_src(gap);
      check(pulse_cnt == base + 1, "R2", pulse_cnt - base, 1);
      // events counted from reset: odd raise the level, even lower it
      if (events_sent % 2 == 1)
        check(last_lat >= 2 && last_lat <= 3, "R4", last_lat, 2);
      else
        check(last_lat >= 2 && last_lat <= 3, "R5", last_lat, 2);
    end
    check(wide_cnt == 0, "R3", wide_cnt, 0);
  endtask

  initial begin
    int base;
    int gap;
    idle_src(3);
    @(negedge src_clk) src_rst_n = 1'b1;
    @(negedge dst_clk) dst_rst_n = 1'b1;
    idle_src(30);
    check(pulse_cnt == 0 && dst_pulse == 1'b0, "R1", pulse_cnt, 0);

    // R8: nearly equal, faster, slower, slightly slower near rate
    sweep_isolated(4.9815, 6);
    sweep_isolated(3.65, 6);
    sweep_isolated(6.55, 6);
    sweep_isolated(5.185, 6);

    // R7: minimum spacing of three destination periods
    for (int k = 0; k < 2; k++) begin
      dst_half = (k == 0) ? 3.65 : 6.55;
      idle_src(4);
      gap = int'($ceil(6.0 * dst_half / 10.0));
      base = pulse_cnt;
      for (int i = 0; i < 16; i++) begin
        launch();
        if (gap > 1) idle_src(gap - 1);
      end
      idle_src(20);
      check(pulse_cnt == base + 16, "R7", pulse_cnt - base, 16);
      check(wide_cnt == 0, "R3", wide_cnt, 0);
    end

    // R6: reset both domains with the crossing level at 1
    dst_half = 4.9815;
    idle_src(4);
    if (events_sent % 2 == 0) begin
      launch();
      idle_src(10);
    end
    base = pulse_cnt;
    #0.3 src_rst_n = 1'b0;
    dst_rst_n = 1'b0;
    idle_src(3);
    @(negedge src_clk) src_rst_n = 1'b1;
    @(negedge dst_clk) dst_rst_n = 1'b1;
    events_sent = 0;
    idle_src(30);
    check(pulse_cnt == base, "R6", pulse_cnt - base, 0);
    launch();
    idle_src(10);
    check(pulse_cnt == base + 1, "R6", pulse_cnt - base, 1);
    check(last_lat >= 2 && last_lat <= 3, "R4", last_lat, 2);

    idle_src(30);
    check(pulse_cnt == base + 1, "R1", pulse_cnt - base, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule